// File: doc/BRIEF.md
# Tiered Access-Enable Register Bank

This block is the part of a privileged control-register file that holds access-enable words. There are three levels: machine, hypervisor and supervisor. Each level has four 64-bit registers, and each register is addressed by its own 12-bit control-register number. A 32-bit core reaches the upper half of each machine-level and hypervisor-level word through a second alias address. Software running at a higher level decides which bits the level below may set. A write to a lower-level register can therefore only change bits that the matching register one level up has opened.

Reads are purely combinational. A write commits on the rising clock edge. An access is refused with an illegal-instruction flag, and state is left untouched, in two cases: the feature input is low, or the requester's privilege is too low for the addressed level. Addresses outside the bank produce no flag and read as zero, so the surrounding file can decode them.

Top module: `tier_enable_bank`

## Requirements
- R1: After reset, every register in all three levels reads as zero.
- R2: The machine registers decode at 0x30C+i, with upper aliases at 0x31C+i. The hypervisor registers decode at 0x60C+i, with upper aliases at 0x61C+i. The supervisor registers decode at 0x10C+i, for i from 0 to 3. The supervisor level has no alias, so 0x11C+i is not part of the bank.
- R3: In a machine register only bit 63 can be written. Bits 62:0 always read as zero.
- R4: A hypervisor write can change bit 63 only when bit 63 of the machine register with the same index is set. Otherwise the register keeps its value.
- R5: A supervisor write can change bit 63 only when bit 63 of the hypervisor register with the same index is set. When virtMode is high, bit 63 of the machine register with the same index must also be set. Clearing a higher-level bit does not clear lower-level contents already written.
- R6: An alias write places wrData[31:0] into bits 63:32, keeps bits 31:0, and then applies the normal mask. An alias read returns bits 63:32 in rdData[31:0], with rdData[63:32] at zero.
- R7: While featureEn is low, every access inside the bank raises illegal and changes no state.
- R8: privLvl is encoded 0 for user, 1 for supervisor and 3 for machine; the value 2 is treated as user. Machine registers may be accessed at any privilege. Hypervisor registers need machine privilege, or supervisor privilege with virtMode low. Supervisor registers need supervisor or machine privilege. Any other access raises illegal and changes no state.
- R9: When illegal is raised, or the address is outside the bank, rdData is zero. Outside the bank, illegal and addrHit stay low.
- R10: State changes only on a clock edge where accEn and wrEn are both high and illegal is low. During a write cycle, rdData shows the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| featureEn | input | 1 | Feature enable; when low, every access to the bank is refused |
| privLvl | input | 2 | Requester privilege (0 user, 1 supervisor, 3 machine) |
| virtMode | input | 1 | Requester is running virtualized |
| accEn | input | 1 | A control-register access is presented this cycle |
| wrEn | input | 1 | The access is a write |
| csrAddr | input | 12 | Control-register address |
| wrData | input | 64 | Write data (alias writes use bits 31:0) |
| rdData | output | 64 | Combinational read data |
| addrHit | output | 1 | The address falls inside the bank |
| illegal | output | 1 | Access refused (illegal instruction) |

## Verification
A read and a write of the same register happen in the same cycle on every write, because the read path stays live while the update waits for the edge. Each write vector in the bench's table carries the value held before the write as its expected read, and the next vector reads back the committed value. The mask cascade meets the half-word merge when an alias write clears a machine bit that a lower-level write depends on. The bench provokes this case and then judges a virtualized supervisor write against the closed machine bit.

// File: rtl/tbank_pkg.sv
package tbank_pkg;
  localparam int unsigned SLOT_CNT = 4;
  localparam int unsigned SLOT_W = 2;

  typedef enum logic [1:0] {
    TIER_NONE = 2'd0,
    TIER_MACH = 2'd1,
    TIER_HYP  = 2'd2,
    TIER_SUP  = 2'd3
  } tier_e;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef struct packed {
    tier_e             tier;
    logic              upper;
    logic [SLOT_W-1:0] slot;
    logic              illegal;
    logic              commit;
  } bank_strobe_t;
endpackage

// File: rtl/tbank_ctrl.sv
module tbank_ctrl
  import tbank_pkg::*;
#(
  parameter int unsigned REG_CNT   = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [11:0] MACH_BASE = 12'h30C,
  parameter logic [11:0] HYP_BASE  = 12'h60C,
  parameter logic [11:0] SUP_BASE  = 12'h10C,
  parameter logic [11:0] HALF_OFS  = 12'h010
) (
  input  logic              featureEn,
  input  logic [1:0]        privLvl,
  input  logic              virtMode,
  input  logic              accEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] csrAddr,
  output bank_strobe_t      strobe,
  output logic              addrHit
);
  localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(REG_CNT);

  logic [ADDR_W-1:0] offMach, offMachHi, offHyp, offHypHi, offSup;
  logic privOk;
  logic inBank;

  assign offMach   = csrAddr - ADDR_W'(MACH_BASE);
  assign offMachHi = csrAddr - ADDR_W'(MACH_BASE + HALF_OFS);
  assign offHyp    = csrAddr - ADDR_W'(HYP_BASE);
  assign offHypHi  = csrAddr - ADDR_W'(HYP_BASE + HALF_OFS);
  assign offSup    = csrAddr - ADDR_W'(SUP_BASE);

  always_comb begin
    strobe.tier  = TIER_NONE;
    strobe.upper = 1'b0;
    strobe.slot  = '0;
    if (offMach < CNT_A) begin
      strobe.tier = TIER_MACH;
      strobe.slot = offMach[SLOT_W-1:0];
    end else if (offMachHi < CNT_A) begin
      strobe.tier  = TIER_MACH;
      strobe.upper = 1'b1;
      strobe.slot  = offMachHi[SLOT_W-1:0];
    end else if (offHyp < CNT_A) begin
      strobe.tier = TIER_HYP;
      strobe.slot = offHyp[SLOT_W-1:0];
    end else if (offHypHi < CNT_A) begin
      strobe.tier  = TIER_HYP;
      strobe.upper = 1'b1;
      strobe.slot  = offHypHi[SLOT_W-1:0];
    end else if (offSup < CNT_A) begin
      strobe.tier = TIER_SUP;
      strobe.slot = offSup[SLOT_W-1:0];
    end
  end

  always_comb begin
    unique case (strobe.tier)
      TIER_MACH: privOk = 1'b1;
      TIER_HYP:  privOk = (privLvl == PRIV_MACH) ||
                          ((privLvl == PRIV_SUPER) && !virtMode);
      TIER_SUP:  privOk = (privLvl == PRIV_MACH) || (privLvl == PRIV_SUPER);
      default:   privOk = 1'b0;
    endcase
  end

  assign inBank         = accEn && (strobe.tier != TIER_NONE);
  assign strobe.illegal = inBank && (!featureEn || !privOk);
  assign strobe.commit  = inBank && wrEn && !strobe.illegal;
  assign addrHit        = inBank;
endmodule

// File: rtl/tbank_dp.sv
module tbank_dp
  import tbank_pkg::*;
#(
  parameter int unsigned   REG_CNT    = 4,
  parameter int unsigned   DATA_W     = 64,
  parameter logic [63:0]   MACH_WMASK = 64'h8000_0000_0000_0000,
  parameter logic [63:0]   HYP_WMASK  = 64'h8000_0000_0000_0000,
  parameter logic [63:0]   SUP_WMASK  = 64'h8000_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              virtMode,
  input  bank_strobe_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] machQ [REG_CNT];
  logic [DATA_W-1:0] hypQ  [REG_CNT];
  logic [DATA_W-1:0] supQ  [REG_CNT];

  logic [DATA_W-1:0] machSel, hypSel, supSel, curSel;
  logic [DATA_W-1:0] merged, wMask, nextVal;

  always_comb begin
    machSel = '0;
    hypSel  = '0;
    supSel  = '0;
    for (int i = 0; i < REG_CNT; i++) begin
      if (strobe.slot == SLOT_W'(i)) begin
        machSel = machQ[i];
        hypSel  = hypQ[i];
        supSel  = supQ[i];
      end
    end
  end

  always_comb begin
    unique case (strobe.tier)
      TIER_MACH: begin
        curSel = machSel;
        wMask  = DATA_W'(MACH_WMASK);
      end
      TIER_HYP: begin
        curSel = hypSel;
        wMask  = DATA_W'(HYP_WMASK) & machSel;
      end
      TIER_SUP: begin
        curSel = supSel;
        wMask  = DATA_W'(SUP_WMASK) & hypSel & (virtMode ? machSel : '1);
      end
      default: begin
        curSel = '0;
        wMask  = '0;
      end
    endcase
  end

  assign merged  = strobe.upper ? {wrData[HALF_W-1:0], curSel[HALF_W-1:0]} : wrData;
  assign nextVal = (curSel & ~wMask) | (merged & wMask);

  always_comb begin
    if (strobe.illegal || strobe.tier == TIER_NONE) begin
      rdData = '0;
    end else if (strobe.upper) begin
      rdData = {{HALF_W{1'b0}}, curSel[DATA_W-1:HALF_W]};
    end else begin
      rdData = curSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) begin
        machQ[i] <= '0;
        hypQ[i]  <= '0;
        supQ[i]  <= '0;
      end
    end else if (strobe.commit) begin
      for (int i = 0; i < REG_CNT; i++) begin
        if (strobe.slot == SLOT_W'(i)) begin
          if (strobe.tier == TIER_MACH) machQ[i] <= nextVal;
          if (strobe.tier == TIER_HYP)  hypQ[i]  <= nextVal;
          if (strobe.tier == TIER_SUP)  supQ[i]  <= nextVal;
        end
      end
    end
  end
endmodule

// File: rtl/tier_enable_bank.sv
module tier_enable_bank
  import tbank_pkg::*;
#(
  parameter int unsigned REG_CNT    = 4,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [63:0] MACH_WMASK = 64'h8000_0000_0000_0000,
  parameter logic [63:0] HYP_WMASK  = 64'h8000_0000_0000_0000,
  parameter logic [63:0] SUP_WMASK  = 64'h8000_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              featureEn,
  input  logic [1:0]        privLvl,
  input  logic              virtMode,
  input  logic              accEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              addrHit,
  output logic              illegal
);
  bank_strobe_t strobe;

  tbank_ctrl #(
    .REG_CNT(REG_CNT),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .featureEn(featureEn),
    .privLvl  (privLvl),
    .virtMode (virtMode),
    .accEn    (accEn),
    .wrEn     (wrEn),
    .csrAddr  (csrAddr),
    .strobe   (strobe),
    .addrHit  (addrHit)
  );

  tbank_dp #(
    .REG_CNT   (REG_CNT),
    .DATA_W    (DATA_W),
    .MACH_WMASK(MACH_WMASK),
    .HYP_WMASK (HYP_WMASK),
    .SUP_WMASK (SUP_WMASK)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .virtMode(virtMode),
    .strobe  (strobe),
    .wrData  (wrData),
    .rdData  (rdData)
  );

  assign illegal = strobe.illegal;
endmodule

// File: rtl/tbank_checker.sv
module tbank_checker (
  input logic        clk,
  input logic        rstN,
  input logic        featureEn,
  input logic [1:0]  privLvl,
  input logic        accEn,
  input logic [11:0] csrAddr,
  input logic [63:0] rdData,
  input logic        addrHit,
  input logic        illegal
);
  AST_FEATURE_OFF_REFUSES: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && addrHit && !featureEn) |-> illegal); // R7

  AST_MACH_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && !illegal && csrAddr[11:4] == 8'h30) |-> (rdData[62:0] == 63'd0)); // R3

  AST_ALIAS_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && !illegal && (csrAddr[11:4] == 8'h31 || csrAddr[11:4] == 8'h61))
      |-> (rdData[63:32] == 32'd0)); // R6

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !addrHit |-> (rdData == 64'd0 && !illegal)); // R9

  AST_REFUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (rdData == 64'd0)); // R9

  AST_USER_LOWER_TIERS: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && privLvl == 2'd0 && csrAddr[11:8] != 4'h3) |-> illegal); // R8
endmodule

bind tier_enable_bank tbank_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .featureEn(featureEn),
  .privLvl  (privLvl),
  .accEn    (accEn),
  .csrAddr  (csrAddr),
  .rdData   (rdData),
  .addrHit  (addrHit),
  .illegal  (illegal)
);

// File: tb/tier_enable_bank_tb.sv
module tier_enable_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        featureEn = 1'b1;
  logic [1:0]  privLvl = 2'd3;
  logic        virtMode = 1'b0;
  logic        accEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        addrHit;
  logic        illegal;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tier_enable_bank u_dut (
    .clk(clk), .rstN(rstN), .featureEn(featureEn), .privLvl(privLvl),
    .virtMode(virtMode), .accEn(accEn), .wrEn(wrEn), .csrAddr(csrAddr),
    .wrData(wrData), .rdData(rdData), .addrHit(addrHit), .illegal(illegal)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [11:0] addr;
    logic        acc;
    logic        wr;
    logic [63:0] data;
    logic [1:0]  priv;
    logic        virt;
    logic        feat;
    logic [63:0] expRd;
    logic        expIll;
  } vec_t;

  localparam logic [63:0] B  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] HB = 64'h0000_0000_8000_0000;
  localparam logic [63:0] F  = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 36;

  localparam vec_t VECS [NV] = '{
    '{4'd1,  12'h30C, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R1
    '{4'd2,  12'h11C, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R2 no alias
    '{4'd10, 12'h10C, 1'b1, 1'b1, F,     2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R10 old value
    '{4'd5,  12'h10C, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R5 closed
    '{4'd4,  12'h60C, 1'b1, 1'b1, F,     2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R4
    '{4'd4,  12'h60C, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R4 closed
    '{4'd3,  12'h30C, 1'b1, 1'b1, F,     2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R3
    '{4'd3,  12'h30C, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, B,     1'b0}, // R3 only bit 63
    '{4'd6,  12'h31C, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, HB,    1'b0}, // R6 alias read
    '{4'd4,  12'h60C, 1'b1, 1'b1, F,     2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R4
    '{4'd4,  12'h60C, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, B,     1'b0}, // R4 open
    '{4'd5,  12'h10C, 1'b1, 1'b1, F,     2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R5
    '{4'd5,  12'h10C, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, B,     1'b0}, // R5 open
    '{4'd3,  12'h30D, 1'b1, 1'b1, F,     2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R3
    '{4'd6,  12'h61D, 1'b1, 1'b1, HB,    2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R6 alias write
    '{4'd6,  12'h60D, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, B,     1'b0}, // R6
    '{4'd6,  12'h31D, 1'b1, 1'b1, 64'h0, 2'd3, 1'b0, 1'b1, HB,    1'b0}, // R6 alias clear
    '{4'd6,  12'h30D, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R6
    '{4'd5,  12'h10D, 1'b1, 1'b1, F,     2'd1, 1'b1, 1'b1, 64'h0, 1'b0}, // R5 virt
    '{4'd5,  12'h10D, 1'b1, 1'b0, 64'h0, 2'd1, 1'b1, 1'b1, 64'h0, 1'b0}, // R5 virt closed
    '{4'd5,  12'h10D, 1'b1, 1'b1, F,     2'd1, 1'b0, 1'b1, 64'h0, 1'b0}, // R5 non-virt
    '{4'd5,  12'h10D, 1'b1, 1'b0, 64'h0, 2'd1, 1'b0, 1'b1, B,     1'b0}, // R5
    '{4'd8,  12'h60E, 1'b1, 1'b1, F,     2'd1, 1'b1, 1'b1, 64'h0, 1'b1}, // R8
    '{4'd8,  12'h10E, 1'b1, 1'b1, F,     2'd0, 1'b0, 1'b1, 64'h0, 1'b1}, // R8
    '{4'd8,  12'h60C, 1'b1, 1'b0, 64'h0, 2'd0, 1'b0, 1'b1, 64'h0, 1'b1}, // R8
    '{4'd8,  12'h60C, 1'b1, 1'b0, 64'h0, 2'd1, 1'b0, 1'b1, B,     1'b0}, // R8
    '{4'd8,  12'h30C, 1'b1, 1'b0, 64'h0, 2'd0, 1'b0, 1'b1, B,     1'b0}, // R8 machine any
    '{4'd7,  12'h30F, 1'b1, 1'b1, F,     2'd3, 1'b0, 1'b0, 64'h0, 1'b1}, // R7
    '{4'd7,  12'h30F, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R7 unchanged
    '{4'd4,  12'h60C, 1'b1, 1'b1, 64'h0, 2'd3, 1'b0, 1'b1, B,     1'b0}, // R4 clear
    '{4'd4,  12'h60C, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R4
    '{4'd5,  12'h10C, 1'b1, 1'b1, 64'h0, 2'd3, 1'b0, 1'b1, B,     1'b0}, // R5
    '{4'd5,  12'h10C, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, B,     1'b0}, // R5 kept
    '{4'd9,  12'h123, 1'b1, 1'b1, F,     2'd3, 1'b0, 1'b0, 64'h0, 1'b0}, // R9
    '{4'd10, 12'h30E, 1'b0, 1'b1, F,     2'd3, 1'b0, 1'b1, 64'h0, 1'b0}, // R10 no accEn
    '{4'd10, 12'h30E, 1'b1, 1'b0, 64'h0, 2'd3, 1'b0, 1'b1, 64'h0, 1'b0}  // R10
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readAt(input logic [11:0] a);
    @(negedge clk);
    accEn = 1'b1; wrEn = 1'b0; csrAddr = a; wrData = '0;
    privLvl = 2'd3; virtMode = 1'b0; featureEn = 1'b1;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      csrAddr = VECS[k].addr; accEn = VECS[k].acc; wrEn = VECS[k].wr;
      wrData = VECS[k].data; privLvl = VECS[k].priv; virtMode = VECS[k].virt;
      featureEn = VECS[k].feat;
      #1;
      check($sformatf("R%0d row %0d rdData", VECS[k].req, k), rdData, VECS[k].expRd);
      check($sformatf("R%0d row %0d illegal", VECS[k].req, k), 64'(illegal), 64'(VECS[k].expIll));
    end

    // R1: reset clears every level
    @(negedge clk);
    accEn = 1'b0; wrEn = 1'b0;
    rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    readAt(12'h30C); check("R1 machine 0 after reset", rdData, 64'h0);
    readAt(12'h60C); check("R1 hyp 0 after reset", rdData, 64'h0);
    readAt(12'h10D); check("R1 sup 1 after reset", rdData, 64'h0);
    readAt(12'h61D); check("R1 hyp 1 alias after reset", rdData, 64'h0);
    // R2: hit flag at the edges of each window
    readAt(12'h30F); check("R2 hit 0x30F", 64'(addrHit), 64'd1);
    readAt(12'h310); check("R2 miss 0x310", 64'(addrHit), 64'd0);
    readAt(12'h61F); check("R2 hit 0x61F", 64'(addrHit), 64'd1);
    readAt(12'h10B); check("R2 miss 0x10B", 64'(addrHit), 64'd0);

    @(negedge clk) accEn = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule